// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog with a refresh window. Software writes a 7-bit down-counter and sets a one-way start bit. From then on the counter steps down once per prescaled tick. Software has to reload the counter regularly, and the reload counts only while the counter value is at or below a programmed window value. The block requests a system reset in two cases: the counter falls out of its upper half (the step from 0x40 to 0x3F), or software reloads it too early. Before the counter expires, an early-warning flag and an optional interrupt tell software that a reload is due.

The block sits behind a simple single-cycle register bus. There are three registers: control, configuration and status. Reads return data one cycle after the read strobe. The reset request is a one-cycle pulse meant for the system reset controller. A sticky copy of that request shows whether the watchdog has ever fired since the last system reset.

Top module: `wwd_top`

## Requirements
- R1: After system reset, control (address 0) reads 0x7F with the start bit clear, configuration (address 1) reads 0x7F with timebase 0 and the interrupt enable clear, and status (address 2) reads 0. All three outputs are low.
- R2: While the start bit is clear, the counter keeps the last value written and does not step down. A control write then loads the counter without any window check and raises no reset request.
- R3: The start bit is control bit 7. Writing 1 sets it. Writing 0 leaves it unchanged, and only system reset clears it.
- R4: While started, the counter in control bits [6:0] steps down by one every 2^(BASE_LOG2+tb) clocks. Here tb is configuration bits [8:7]. Every control write restarts this interval.
- R5: The step of the counter from 0x40 to 0x3F raises the reset request output for exactly one cycle, in the cycle right after the step.
- R6: When the counter steps down to 0x40, the early-warning flag (status bit 0) is set. The interrupt output equals the flag ANDed with the enable in configuration bit 9, and it changes in the same cycle as the flag.
- R7: Writing 1 to configuration bit 9 sets the interrupt enable. Writing 0 to it has no effect until system reset.
- R8: Writing 0 to status bit 0 clears the early-warning flag. Writing 1 leaves the flag unchanged. When a flag set and a clear happen in the same cycle, the set wins.
- R9: A control write while started and while the counter is above the window value (configuration bits [6:0]) raises a one-cycle reset request, and the counter still loads. A control write at or below the window raises none.
- R10: The reset-seen output goes high with the first reset request and stays high until system reset.
- R11: A read strobe returns the addressed register on the read data output in the next cycle, with the unused bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register select: 0 control, 1 configuration, 2 status |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after bus_rd |
| wdt_rst_req | output | 1 | One-cycle system reset request |
| wdt_warn_irq | output | 1 | Early-warning interrupt |
| wdt_rst_seen | output | 1 | Sticky record of any reset request |

## Verification
The assertions check on every cycle the properties that hold whatever the stimulus:
- the start bit and the interrupt enable never clear;
- an idle counter never moves, and a started counter moves only by single steps on a tick;
- a step from 0x40 is always followed by a reset request;
- the reset-seen bit is sticky.

The exact tick spacing for each timebase, the window decision on each reload, and the order of flag set and clear need the bench. Its behavioural model follows the counter through activation, early and in-window reloads, expiry, counter wrap-around and a slow timebase, and compares every output on every clock.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int CNT_W = 7;
  localparam int WIN_W = 7;
  localparam int TB_W  = 2;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  localparam logic [CNT_W-1:0] CNT_INIT   = 7'h7F;
  localparam logic [WIN_W-1:0] WIN_INIT   = 7'h7F;
  localparam logic [CNT_W-1:0] CNT_EXPIRE = 7'h40;
  localparam logic [CNT_W-1:0] CNT_WARN   = 7'h41;
endpackage

// File: rtl/wwd_tick_gen.sv
module wwd_tick_gen #(
  parameter int BASE_LOG2 = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] tb,
  output logic       tick
);
  localparam int DIV_W = BASE_LOG2 + 4;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;
  logic             at_limit;

  assign limit    = ({{(DIV_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(tb))) - 1'b1;
  assign at_limit = (div_q >= limit);
  assign tick     = run && !clear && at_limit;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= at_limit ? '0 : div_q + 1'b1;
    end
  end

  p_tick_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
    tick |-> run);
  p_div_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(div_q));
endmodule

// File: rtl/wwd_core.sv
module wwd_core
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  input  logic             cfg_wr,
  input  logic [9:0]       cfg_wdata,
  input  logic             stat_wr,
  input  logic             stat_bit,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic [WIN_W-1:0] window,
  output logic [TB_W-1:0]  tbsel,
  output logic             warn_en,
  output logic             warn_flag,
  output logic             rst_req,
  output logic             warn_irq,
  output logic             rst_seen
);
  logic             viol, step, expire, reach;
  logic [CNT_W-1:0] cnt_n;
  logic             active_n, en_n, flag_n;

  always_comb begin
    viol     = ctrl_wr && active && (cnt > window);
    step     = !ctrl_wr && active && tick;
    expire   = step && (cnt == CNT_EXPIRE);
    reach    = step && (cnt == CNT_WARN);
    cnt_n    = ctrl_wr ? ctrl_wdata[CNT_W-1:0] : (step ? cnt - 1'b1 : cnt);
    active_n = active || (ctrl_wr && ctrl_wdata[7]);
    en_n     = warn_en || (cfg_wr && cfg_wdata[9]);
    if (reach)                     flag_n = 1'b1;
    else if (stat_wr && !stat_bit) flag_n = 1'b0;
    else                           flag_n = warn_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= CNT_INIT;
      active    <= 1'b0;
      window    <= WIN_INIT;
      tbsel     <= '0;
      warn_en   <= 1'b0;
      warn_flag <= 1'b0;
      rst_req   <= 1'b0;
      warn_irq  <= 1'b0;
      rst_seen  <= 1'b0;
    end else begin
      cnt       <= cnt_n;
      active    <= active_n;
      warn_en   <= en_n;
      warn_flag <= flag_n;
      warn_irq  <= flag_n && en_n;
      rst_req   <= expire || viol;
      rst_seen  <= rst_seen || expire || viol;
      if (cfg_wr) begin
        window <= cfg_wdata[WIN_W-1:0];
        tbsel  <= cfg_wdata[8:7];
      end
    end
  end

  p_active_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    active |=> active);
  p_en_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    warn_en |=> warn_en);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!active && !ctrl_wr) |=> $stable(cnt));
  p_no_step_r4: assert property (@(posedge clk) disable iff (rst)
    (active && !ctrl_wr && !tick) |=> $stable(cnt));
  p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
    (active && !ctrl_wr && tick) |=> (cnt == $past(cnt) - 7'd1));
  p_expire_r5: assert property (@(posedge clk) disable iff (rst)
    (active && !ctrl_wr && tick && cnt == CNT_EXPIRE) |=> rst_req);
  p_seen_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    rst_seen |=> rst_seen);
  p_seen_with_req_r10: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> rst_seen);
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
    warn_irq |-> (warn_flag && warn_en));
endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 2,
  parameter int BASE_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wdt_rst_req,
  output logic          wdt_warn_irq,
  output logic          wdt_rst_seen
);
  localparam int USED_W = 10;

  logic             sel_ctrl, sel_cfg, sel_stat;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             active, warn_en, warn_flag;
  logic [WIN_W-1:0] window;
  logic [TB_W-1:0]  tbsel;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:USED_W];
  assign sel_ctrl = bus_wr && (bus_addr == AW'(SEL_CTRL));
  assign sel_cfg  = bus_wr && (bus_addr == AW'(SEL_CFG));
  assign sel_stat = bus_wr && (bus_addr == AW'(SEL_STAT));

  wwd_tick_gen #(.BASE_LOG2(BASE_LOG2)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .run   (active),
    .clear (sel_ctrl),
    .tb    (tbsel),
    .tick  (tick)
  );

  wwd_core u_core (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (sel_ctrl),
    .ctrl_wdata (bus_wdata[7:0]),
    .cfg_wr     (sel_cfg),
    .cfg_wdata  (bus_wdata[9:0]),
    .stat_wr    (sel_stat),
    .stat_bit   (bus_wdata[0]),
    .tick       (tick),
    .cnt        (cnt),
    .active     (active),
    .window     (window),
    .tbsel      (tbsel),
    .warn_en    (warn_en),
    .warn_flag  (warn_flag),
    .rst_req    (wdt_rst_req),
    .warn_irq   (wdt_warn_irq),
    .rst_seen   (wdt_rst_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        AW'(SEL_CTRL): bus_rdata[7:0] <= {active, cnt};
        AW'(SEL_CFG):  bus_rdata[9:0] <= {warn_en, tbsel, window};
        AW'(SEL_STAT): bus_rdata[0]   <= warn_flag;
        default:       bus_rdata      <= '0;
      endcase
    end
  end

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_wwd_top.sv
module tb_wwd_top;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam int BL = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          wdt_rst_req, wdt_warn_irq, wdt_rst_seen;

  always #4 clk = ~clk;

  wwd_top #(.DW(DW), .AW(AW), .BASE_LOG2(BL)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_req(wdt_rst_req), .wdt_warn_irq(wdt_warn_irq),
    .wdt_rst_seen(wdt_rst_seen)
  );

  // behavioural reference state
  int m_cnt, m_act, m_win, m_tb, m_en, m_flag, m_div;
  int e_req, e_irq, e_seen, e_rdata;
  bit rd_pend;
  string rd_tag = "R11";
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int ev, setf, rdv, lim;
    if (rst) begin
      m_cnt = 'h7F; m_act = 0; m_win = 'h7F; m_tb = 0; m_en = 0; m_flag = 0;
      m_div = 0; e_req = 0; e_irq = 0; e_seen = 0; e_rdata = 0; rd_pend = 0;
    end else begin
      ev = 0; setf = 0;
      rd_pend = bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          0: rdv = (m_act << 7) | m_cnt;
          1: rdv = (m_en << 9) | (m_tb << 7) | m_win;
          2: rdv = m_flag;
          default: rdv = 0;
        endcase
        e_rdata = rdv;
      end
      lim = (1 << (BL + m_tb)) - 1;
      if (bus_wr && bus_addr == 0) begin
        if (m_act != 0 && m_cnt > m_win) ev = 1;
        m_cnt = bus_wdata[6:0];
        if (bus_wdata[7]) m_act = 1;
        m_div = 0;
      end else if (m_act != 0) begin
        if (m_div >= lim) begin
          m_div = 0;
          if (m_cnt == 'h41) setf = 1;
          if (m_cnt == 'h40) ev = 1;
          m_cnt = (m_cnt - 1) & 'h7F;
        end else m_div++;
      end
      if (bus_wr && bus_addr == 1) begin
        m_win = bus_wdata[6:0]; m_tb = bus_wdata[8:7];
        if (bus_wdata[9]) m_en = 1;
      end
      if (setf) m_flag = 1;
      else if (bus_wr && bus_addr == 2 && !bus_wdata[0]) m_flag = 0;
      e_req = ev;
      if (ev) e_seen = 1;
      e_irq = m_flag & m_en;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R5 R9 reset request", int'(wdt_rst_req), e_req);
      check("R6 R7 R8 warning irq", int'(wdt_warn_irq), e_irq);
      check("R10 reset seen", int'(wdt_rst_seen), e_seen);
      if (rd_pend) check(rd_tag, int'(bus_rdata), e_rdata);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a); rd_tag = tag;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    check("R1 outputs low", int'({wdt_rst_req, wdt_warn_irq, wdt_rst_seen}), 0);
    rd(0, "R1 control reset");
    rd(1, "R1 config reset");
    rd(2, "R1 status reset");
    // R2 idle counter holds and loads with no window check
    wr(1, 'h50);
    wr(0, 'h7E);
    idle(40);
    rd(0, "R2 idle counter hold");
    // R3 start with window 0x60, enable irq (R7)
    wr(1, 'h200 | 'h60);
    rd(1, "R7 enable set");
    wr(0, 'h80 | 'h7F);
    idle(20);
    rd(0, "R4 stepping tb0");
    idle(120);
    wr(0, 'hFF);            // R9 in-window refresh, no request
    wr(0, 'h7F);            // R9 too early, request; R3 bit7=0 ignored
    rd(0, "R3 start bit kept");
    idle(300);              // R5 expiry and R6 warning
    rd(2, "R6 flag set");
    wr(2, 1);
    rd(2, "R8 write one keeps flag");
    wr(2, 0);
    rd(2, "R8 write zero clears");
    // R4 slow timebase, R7 enable cannot clear
    wr(1, 'h180 | 'h60);
    rd(1, "R7 enable kept");
    wr(0, 'hFF);
    idle(200);
    rd(0, "R4 stepping tb3");
    idle(2600);
    rd(2, "R6 flag tb3");
    rd(0, "R11 control readback");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule